// File: doc/BRIEF.md
# Trap-Return State Unit

This unit decodes and carries out the three trap-return instructions of a RISC-V style hart: return from a supervisor trap, return from a machine trap and return from a resumable non-maskable interrupt. It looks at a 32-bit instruction word together with the hart's current privilege level, its virtualization bit, the trap-control bit for supervisor returns and the saved status fields and exception PCs. From these it decides whether the word is a trap return and, if so, whether it may run.

When the commit strobe is high, a legal return loads the complete set of new state in that clock edge: privilege, virtualization bit, interrupt enables, saved-mode fields, double-trap and modify-privilege flags, and the redirect PC. On the next cycle the unit raises a one-cycle update pulse. An illegal return raises a one-cycle trap pulse instead and leaves all state untouched. Every other SYSTEM instruction is reported as not being a trap return. Parameters remove supervisor mode, user mode or resumable-NMI support, and a return that needs an absent feature then traps.

Top module: `trap_return_unit`

## Requirements
- R1: A word is a trap return only when bits 6:0 = 1110011, bits 14:12 = 000, bits 24:20 = 00010, bits 19:15 = 0 and bits 11:7 = 0. Bits 31:25 then select the kind: 0001000 for supervisor return, 0011000 for machine return and 0111000 for NMI return. `is_ret_o` is high exactly for these words.
- R2: Machine return sets privilege to `mpp_i`, copies `mpie_i` into `mie_o`, sets `mpie_o` to 1 and sets `mpp_o` to the lowest supported mode (0 with user mode, else 3). Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R3: Machine return sets the virtualization bit to `mpv_i`, or to 0 when `mpp_i` = 3.
- R4: Machine return clears `mdt_o`. Any legal return whose new privilege is below 3 clears `mprv_o`; otherwise `mprv_o` takes `mprv_i`.
- R5: Supervisor return sets privilege to {0,`spp_i`}, copies `spie_i` into `sie_o`, sets `spie_o` to 1 and `spp_o` to 0.
- R6: Supervisor return leaves the virtualization bit at 1 when `virt_i` = 1 and loads it from `spv_i` when `virt_i` = 0.
- R7: NMI return sets privilege to `mnpp_i`, sets the virtualization bit to `mnpv_i` (0 when `mnpp_i` = 3) and sets `nmie_o`.
- R8: Machine and NMI returns are illegal below privilege 3. Supervisor return is illegal at privilege 0, and at privilege 1 when `tsr_i` = 1.
- R9: With `HAS_RNMI` = 0 every NMI return is illegal, and with `HAS_SMODE` = 0 every supervisor return is illegal.
- R10: The redirect PC is `mepc_i`, `sepc_i` or `mnepc_i` for machine, supervisor or NMI return, with bit 0 forced to 0.
- R11: State is loaded only at a clock edge where `commit_i` is high and the word is a legal return. Fields that the return does not change take their input values. The next cycle `upd_o` = 1. After an illegal return `trap_o` = 1 and all state holds. After a non-return word, or with `commit_i` low, both pulses are 0 and all state holds.
- R12: After reset `priv_o` = 3 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| commit_i | input | 1 | Commit strobe |
| priv_i | input | 2 | Current privilege |
| virt_i | input | 1 | Current virtualization bit |
| tsr_i | input | 1 | Trap supervisor returns |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Saved machine interrupt enable |
| mpp_i | input | 2 | Saved machine-trap privilege |
| mpv_i | input | 1 | Saved machine-trap virtualization |
| mdt_i | input | 1 | Machine double-trap flag |
| mprv_i | input | 1 | Modify-privilege flag |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Saved supervisor interrupt enable |
| spp_i | input | 1 | Saved supervisor-trap privilege |
| spv_i | input | 1 | Saved supervisor-trap virtualization |
| mnpp_i | input | 2 | Saved NMI privilege |
| mnpv_i | input | 1 | Saved NMI virtualization |
| nmie_i | input | 1 | NMI enable |
| mepc_i | input | XLEN | Machine exception PC |
| sepc_i | input | XLEN | Supervisor exception PC |
| mnepc_i | input | XLEN | NMI exception PC |
| is_ret_o | output | 1 | Word is a trap return |
| illegal_o | output | 1 | Trap return is not permitted now |
| upd_o | output | 1 | New state loaded last edge |
| trap_o | output | 1 | Illegal return committed last edge |
| pc_o | output | XLEN | Redirect PC |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization bit |
| mie_o | output | 1 | New machine interrupt enable |
| mpie_o | output | 1 | New saved machine interrupt enable |
| mpp_o | output | 2 | New saved machine privilege |
| mdt_o | output | 1 | New double-trap flag |
| mprv_o | output | 1 | New modify-privilege flag |
| sie_o | output | 1 | New supervisor interrupt enable |
| spie_o | output | 1 | New saved supervisor interrupt enable |
| spp_o | output | 1 | New saved supervisor privilege |
| nmie_o | output | 1 | New NMI enable |

## Verification
The sweep crosses every return kind with each privilege level, both virtualization values, both trap-control values, the saved privileges 0, 1 and 3 and both saved virtualization bits. This separates machine return to machine from machine return below it, and supervisor return made from a guest from one made from the host. The enable bits and odd exception PCs change from vector to vector, so a wrong source field or an unmasked PC bit shows up. Near-miss words and vectors with the commit strobe low test that state holds. A second instance without supervisor and NMI support runs the same vectors to test that those returns trap.

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_UMODE = 1'b1,
  parameter bit HAS_RNMI  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     insn_i,
  input  logic            commit_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            tsr_i,
  input  logic            mie_i,
  input  logic            mpie_i,
  input  logic [1:0]      mpp_i,
  input  logic            mpv_i,
  input  logic            mdt_i,
  input  logic            mprv_i,
  input  logic            sie_i,
  input  logic            spie_i,
  input  logic            spp_i,
  input  logic            spv_i,
  input  logic [1:0]      mnpp_i,
  input  logic            mnpv_i,
  input  logic            nmie_i,
  input  logic [XLEN-1:0] mepc_i,
  input  logic [XLEN-1:0] sepc_i,
  input  logic [XLEN-1:0] mnepc_i,
  output logic            is_ret_o,
  output logic            illegal_o,
  output logic            upd_o,
  output logic            trap_o,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic            virt_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic            mdt_o,
  output logic            mprv_o,
  output logic            sie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            nmie_o
);
  localparam logic [1:0] PRV_U   = 2'd0;
  localparam logic [1:0] PRV_S   = 2'd1;
  localparam logic [1:0] PRV_M   = 2'd3;
  localparam logic [1:0] LOW_PRV = HAS_UMODE ? PRV_U : PRV_M;

  typedef enum logic [1:0] {K_NONE, K_SRET, K_MRET, K_MNRET} kind_t;

  wire shape_ok = insn_i[6:0] == 7'b1110011 && insn_i[14:12] == 3'b000 &&
                  insn_i[24:20] == 5'b00010 && insn_i[19:15] == 5'd0 &&
                  insn_i[11:7] == 5'd0;

  kind_t kind;
  always_comb begin
    kind = K_NONE;
    if (shape_ok)
      case (insn_i[31:25])
        7'b0001000: kind = K_SRET;
        7'b0011000: kind = K_MRET;
        7'b0111000: kind = K_MNRET;
        default:    kind = K_NONE;
      endcase
  end

  logic illegal;
  always_comb
    case (kind)
      K_SRET:  illegal = !HAS_SMODE || priv_i == PRV_U || (priv_i == PRV_S && tsr_i);
      K_MRET:  illegal = priv_i != PRV_M;
      K_MNRET: illegal = !HAS_RNMI || priv_i != PRV_M;
      default: illegal = 1'b0;
    endcase

  assign is_ret_o  = kind != K_NONE;
  assign illegal_o = illegal;
  wire go = commit_i && is_ret_o && !illegal;

  logic [XLEN-1:0] n_pc;
  logic [1:0] n_priv, n_mpp;
  logic n_virt, n_mie, n_mpie, n_mdt, n_mprv, n_sie, n_spie, n_spp, n_nmie;

  always_comb begin
    n_pc = mepc_i;   n_priv = priv_i; n_virt = virt_i;
    n_mie = mie_i;   n_mpie = mpie_i; n_mpp = mpp_i;  n_mdt = mdt_i;
    n_sie = sie_i;   n_spie = spie_i; n_spp = spp_i;  n_nmie = nmie_i;
    case (kind)
      K_MRET: begin
        n_priv = mpp_i;
        n_virt = (mpp_i == PRV_M) ? 1'b0 : mpv_i;
        n_mie  = mpie_i;
        n_mpie = 1'b1;
        n_mpp  = LOW_PRV;
        n_mdt  = 1'b0;
      end
      K_SRET: begin
        n_pc   = sepc_i;
        n_priv = {1'b0, spp_i};
        n_virt = virt_i | spv_i;
        n_sie  = spie_i;
        n_spie = 1'b1;
        n_spp  = 1'b0;
      end
      K_MNRET: begin
        n_pc   = mnepc_i;
        n_priv = mnpp_i;
        n_virt = (mnpp_i == PRV_M) ? 1'b0 : mnpv_i;
        n_nmie = 1'b1;
      end
      default: ;
    endcase
    n_mprv = (n_priv == PRV_M) ? mprv_i : 1'b0;
    n_pc[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      upd_o <= 1'b0; trap_o <= 1'b0; pc_o <= '0; priv_o <= PRV_M; virt_o <= 1'b0;
      mie_o <= 1'b0; mpie_o <= 1'b0; mpp_o <= PRV_U; mdt_o <= 1'b0; mprv_o <= 1'b0;
      sie_o <= 1'b0; spie_o <= 1'b0; spp_o <= 1'b0; nmie_o <= 1'b0;
    end else begin
      upd_o  <= go;
      trap_o <= commit_i && is_ret_o && illegal;
      if (go) begin
        pc_o <= n_pc; priv_o <= n_priv; virt_o <= n_virt;
        mie_o <= n_mie; mpie_o <= n_mpie; mpp_o <= n_mpp; mdt_o <= n_mdt; mprv_o <= n_mprv;
        sie_o <= n_sie; spie_o <= n_spie; spp_o <= n_spp; nmie_o <= n_nmie;
      end
    end

  assert_pc_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> !pc_o[0]);
  assert_mret_from_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && $past(kind == K_MRET || kind == K_MNRET)) |-> $past(priv_i) == PRV_M);
  assert_mret_mdt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && $past(kind == K_MRET)) |-> !mdt_o && mpie_o);
  assert_mprv_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && priv_o != PRV_M) |-> !mprv_o);
  assert_m_not_virt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && priv_o == PRV_M) |-> !virt_o);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |=> $stable(priv_o) || $past(go));
  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_o && trap_o));
endmodule

// File: tb/test_trap_return_unit.sv
`timescale 1ns/1ps
module test_trap_return_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] insn = '0;
  logic commit = 1'b0;
  logic [1:0] b_priv = 2'd3, b_mpp = '0, b_mnpp = '0;
  logic b_virt = 0, b_tsr = 0, b_mie = 0, b_mpie = 0, b_mpv = 0, b_mdt = 0, b_mprv = 0;
  logic b_sie = 0, b_spie = 0, b_spp = 0, b_spv = 0, b_mnpv = 0, b_nmie = 0;
  logic [31:0] b_mepc = '0, b_sepc = '0, b_mnepc = '0;

  logic isr_a, ill_a, upd_a, trp_a, virt_a, mie_a, mpie_a, mdt_a, mprv_a, sie_a, spie_a, spp_a, nmie_a;
  logic [31:0] pc_a; logic [1:0] priv_a, mpp_a;
  logic isr_b, ill_b, upd_b, trp_b, virt_b, mie_b, mpie_b, mdt_b, mprv_b, sie_b, spie_b, spp_b, nmie_b;
  logic [31:0] pc_b; logic [1:0] priv_b, mpp_b;

  trap_return_unit i_trap_return_unit (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .commit_i(commit), .priv_i(b_priv),
    .virt_i(b_virt), .tsr_i(b_tsr), .mie_i(b_mie), .mpie_i(b_mpie), .mpp_i(b_mpp),
    .mpv_i(b_mpv), .mdt_i(b_mdt), .mprv_i(b_mprv), .sie_i(b_sie), .spie_i(b_spie),
    .spp_i(b_spp), .spv_i(b_spv), .mnpp_i(b_mnpp), .mnpv_i(b_mnpv), .nmie_i(b_nmie),
    .mepc_i(b_mepc), .sepc_i(b_sepc), .mnepc_i(b_mnepc),
    .is_ret_o(isr_a), .illegal_o(ill_a), .upd_o(upd_a), .trap_o(trp_a), .pc_o(pc_a),
    .priv_o(priv_a), .virt_o(virt_a), .mie_o(mie_a), .mpie_o(mpie_a), .mpp_o(mpp_a),
    .mdt_o(mdt_a), .mprv_o(mprv_a), .sie_o(sie_a), .spie_o(spie_a), .spp_o(spp_a),
    .nmie_o(nmie_a));

  trap_return_unit #(.HAS_SMODE(1'b0), .HAS_RNMI(1'b0)) i_bare (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .commit_i(commit), .priv_i(b_priv),
    .virt_i(b_virt), .tsr_i(b_tsr), .mie_i(b_mie), .mpie_i(b_mpie), .mpp_i(b_mpp),
    .mpv_i(b_mpv), .mdt_i(b_mdt), .mprv_i(b_mprv), .sie_i(b_sie), .spie_i(b_spie),
    .spp_i(b_spp), .spv_i(b_spv), .mnpp_i(b_mnpp), .mnpv_i(b_mnpv), .nmie_i(b_nmie),
    .mepc_i(b_mepc), .sepc_i(b_sepc), .mnepc_i(b_mnepc),
    .is_ret_o(isr_b), .illegal_o(ill_b), .upd_o(upd_b), .trap_o(trp_b), .pc_o(pc_b),
    .priv_o(priv_b), .virt_o(virt_b), .mie_o(mie_b), .mpie_o(mpie_b), .mpp_o(mpp_b),
    .mdt_o(mdt_b), .mprv_o(mprv_b), .sie_o(sie_b), .spie_o(spie_b), .spp_o(spp_b),
    .nmie_o(nmie_b));

  wire [46:0] got_a = {upd_a, trp_a, pc_a, priv_a, virt_a, mie_a, mpie_a, mpp_a, mdt_a,
                       mprv_a, sie_a, spie_a, spp_a, nmie_a};
  wire [46:0] got_b = {upd_b, trp_b, pc_b, priv_b, virt_b, mie_b, mpie_b, mpp_b, mdt_b,
                       mprv_b, sie_b, spie_b, spp_b, nmie_b};

  int checks = 0, fails = 0;
  logic [44:0] prev_a, prev_b;

  task automatic check(input string req, input logic [46:0] act, input logic [46:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pick3(input int i);
    return (i == 0) ? 2'd0 : (i == 1) ? 2'd1 : 2'd3;
  endfunction

  // k: 0 supervisor return, 1 machine return, 2 NMI return, 3 not a return
  function automatic logic [46:0] model(input int k, input bit hs, input bit hn,
                                        input bit com, input logic [44:0] prev);
    bit ill;
    logic [31:0] pc; logic [1:0] p, mpp; logic v, mie, mpie, mdt, mprv, sie, spie, spp, nmie;
    ill = (k == 0) ? (!hs || b_priv == 0 || (b_priv == 1 && b_tsr)) :
          (k == 1) ? (b_priv != 3) : (k == 2) ? (!hn || b_priv != 3) : 1'b0;
    if (k == 3 || !com) return {2'b00, prev};
    if (ill) return {2'b01, prev};
    pc = b_mepc; p = b_priv; v = b_virt; mie = b_mie; mpie = b_mpie; mpp = b_mpp;
    mdt = b_mdt; sie = b_sie; spie = b_spie; spp = b_spp; nmie = b_nmie;
    if (k == 1) begin
      p = b_mpp; v = (b_mpp == 3) ? 1'b0 : b_mpv; mie = b_mpie; mpie = 1; mpp = 0; mdt = 0;
    end else if (k == 0) begin
      pc = b_sepc; p = {1'b0, b_spp}; v = b_virt ? 1'b1 : b_spv; sie = b_spie; spie = 1; spp = 0;
    end else begin
      pc = b_mnepc; p = b_mnpp; v = (b_mnpp == 3) ? 1'b0 : b_mnpv; nmie = 1;
    end
    mprv = (p == 3) ? b_mprv : 1'b0;
    pc = {pc[31:1], 1'b0};
    return {2'b10, pc, p, v, mie, mpie, mpp, mdt, mprv, sie, spie, spp, nmie};
  endfunction

  function automatic logic [31:0] encode(input int k, input int n);
    logic [6:0] f7;
    f7 = (k == 0) ? 7'b0001000 : (k == 1) ? 7'b0011000 : 7'b0111000;
    if (k < 3) return {f7, 5'b00010, 5'd0, 3'b000, 5'd0, 7'b1110011};
    case (n % 5)
      0: return {7'b0001001, 5'b00010, 5'd0, 3'b000, 5'd0, 7'b1110011};
      1: return {7'b0001000, 5'b00101, 5'd0, 3'b000, 5'd0, 7'b1110011};
      2: return {7'b0011000, 5'b00010, 5'd0, 3'b100, 5'd0, 7'b1110011};
      3: return {7'b0011000, 5'b00010, 5'd0, 3'b000, 5'd0, 7'b0110011};
      default: return {7'b0011000, 5'b00010, 5'd0, 3'b000, 5'd4, 7'b1110011};
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [46:0] ea, eb;
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    prev_a = {32'd0, 2'd3, 11'd0};
    prev_b = prev_a;
    check("R12 reset", got_a, {2'b00, prev_a});
    check("R12 reset bare", got_b, {2'b00, prev_b});
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++)
    for (int pr = 0; pr < 3; pr++)
    for (int vi = 0; vi < 2; vi++)
    for (int ts = 0; ts < 2; ts++)
    for (int mp = 0; mp < 3; mp++)
    for (int mv = 0; mv < 2; mv++)
    for (int sp = 0; sp < 2; sp++)
    for (int sv = 0; sv < 2; sv++)
    for (int np = 0; np < 3; np++)
    for (int nv = 0; nv < 2; nv++) begin
      @(negedge clk);
      n++;
      insn = encode(k, n);
      commit = (n % 7) != 3;
      b_priv = pick3(pr); b_virt = vi[0]; b_tsr = ts[0]; b_mpp = pick3(mp); b_mpv = mv[0];
      b_spp = sp[0]; b_spv = sv[0]; b_mnpp = pick3(np); b_mnpv = nv[0];
      b_mie = n[0]; b_mpie = n[1]; b_mdt = n[2]; b_mprv = n[3];
      b_sie = n[4]; b_spie = n[5]; b_nmie = n[6];
      b_mepc = 32'h8000_0001 ^ (n << 4);
      b_sepc = 32'h4000_0003 ^ (n << 5);
      b_mnepc = 32'h2000_0005 ^ (n << 6);
      ea = model(k, 1'b1, 1'b1, commit, prev_a);
      eb = model(k, 1'b0, 1'b0, commit, prev_b);
      #1;
      check("R1 decode", {46'd0, isr_a}, {46'd0, k < 3});
      @(negedge clk);
      if (k == 3 || !commit) check("R11 hold", got_a, ea);
      else if (k == 1) check(b_mpp == 3 ? "R3 R2 R4 R10 mret to M" : "R3 R2 R4 R10 mret below M", got_a, ea);
      else if (k == 0) check(b_virt ? "R6 R5 R8 R10 sret V=1" : "R6 R5 R8 R10 sret V=0", got_a, ea);
      else check("R7 R8 R10 mnret", got_a, ea);
      check("R9 absent features", got_b, eb);
      prev_a = ea[44:0];
      prev_b = eb[44:0];
      commit = 1'b0;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule